// File: doc/BRIEF.md
# Bus-Mapped Slave Read/Write Register

This block is a single storage register that answers as a slave on an asynchronous master/slave bus with 18 address lines and 16 data lines. On every transfer it compares the upper address bits with a base address set by a parameter. If the address matches, the 2-bit transfer code decides what happens. A read, or a read-with-pause, places the register contents on the read-data lines. A word write loads all sixteen bits. A byte write loads only the byte lane that address bit 0 selects.

The handshake is a simple interlock. The master raises its sync line. The block answers with a slave acknowledge one clock later and holds it until the master sync falls. Any write takes effect on the clock edge that raises the acknowledge.

The register value is also brought out continuously as a parallel port. It can therefore serve as a data register or drive an output device such as a lamp bank. Read data is modelled as a data vector plus a separate drive-enable, not as an internal tri-state.

Top module: `bus_slave_reg`

## Requirements
- R1: A word write (code 10) to a matching address stores all 16 data bits, and `reg_q` shows the new value from the edge on which `ssyn` rises.
- R2: A byte write (code 11) with address bit 0 = 0 updates only bits 7:0. With address bit 0 = 1 it updates only bits 15:8. The other byte keeps its value.
- R3: When address bits 17:1 differ from the base address, the transfer is ignored: `ssyn` stays low, the register is unchanged and `rdata_oe` stays low.
- R4: Address bit 0 plays no part in the match. A word write or a read at the odd address of the pair behaves exactly as at the even address.
- R5: `ssyn` rises one clock after `msyn` is sampled high with a matching address. It stays high while `msyn` stays high, and it falls on the first clock after `msyn` is sampled low.
- R6: A transfer writes at most once. Data that changes on the write-data lines while `ssyn` is already high does not reach the register.
- R7: `rdata_oe` is high exactly while `bus_init_n`, `msyn` and the address match are all true and the code is 00 or 01. While it is high, `rdata` equals the register. At all other times `rdata` is zero.
- R8: Read (code 00) and read-with-pause (code 01) transfers never change the register.
- R9: `bus_init_n` sampled low on a clock edge clears the register and `ssyn` to zero. `rdata_oe` is low whenever `bus_init_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the bus lines are sampled on its rising edge |
| bus_init_n | input | 1 | Bus initialise, synchronous, active low |
| bus_addr | input | 18 | Bus address lines |
| bus_ctl | input | 2 | Transfer code: 00 read, 01 read-with-pause, 10 word write, 11 byte write |
| msyn | input | 1 | Master sync; high for the duration of a transfer |
| wdata | input | 16 | Bus data lines as seen by the receivers |
| ssyn | output | 1 | Slave sync acknowledge |
| rdata | output | 16 | Read data; zero when not driving |
| rdata_oe | output | 1 | Drive-enable for the read data onto the bus |
| reg_q | output | 16 | Parallel register output |

## Verification
Some rules can be checked on every cycle, because each one relates signals across a single clock edge. The assertions cover these: acknowledge rise, hold and release, zero read data whenever the drive-enable is low, a stable register on reads and on cycles where the acknowledge is already held, the untouched upper byte on a low-lane byte write, and no acknowledge on an address miss. Other behaviour needs a history of several transfers, and only the bench scenarios can show it. This includes which exact value lands in the register after a sequence of mixed word and byte writes, that odd and even addresses of the pair behave the same, and that the bus initialise clears a register that was loaded earlier. The bench's cycle-level reference model covers both groups on every clock.

// File: rtl/bus_slave_reg_pkg.sv
// Package: shared transfer-code type for the bus slave register.
// Assumes a 2-bit transfer code on the bus control lines.
package bus_slave_reg_pkg;
    typedef enum logic [1:0] {
        XF_READ       = 2'b00,
        XF_READ_HOLD  = 2'b01,
        XF_WRITE_WORD = 2'b10,
        XF_WRITE_BYTE = 2'b11
    } xfer_e;
endpackage

// File: rtl/bsr_addr_match.sv
// Address comparator: flags a hit when the address bits above the byte-lane
// select field equal the same bits of the base address.
// Assumes LANE_SEL_W >= 1 (at least two byte lanes).
module bsr_addr_match #(
    parameter int                  ADDR_W     = 18,
    parameter int                  LANE_SEL_W = 1,
    parameter logic [ADDR_W-1:0]   BASE_ADDR  = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    // Compare only the word-select bits; lane bits never take part.
    always_comb begin
        hit = (addr[ADDR_W-1:LANE_SEL_W] == BASE_ADDR[ADDR_W-1:LANE_SEL_W]);
    end
endmodule

// File: rtl/bsr_handshake.sv
// Slave acknowledge generator: raises ack one clock after master sync is seen
// with an address hit, holds it while master sync stays high, drops it after.
// Assumes master sync is synchronous to clk.
module bsr_handshake (
    input  logic clk,
    input  logic rst_n,
    input  logic msyn,
    input  logic hit,
    output logic ack
);
    // Acknowledge register: set on a hit, held through the transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) ack <= 1'b0;
        else        ack <= msyn & (ack | hit);
    end

    // R5: acknowledge rises the clock after a hit with master sync
    p_ack_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (msyn && hit && !ack) |=> ack);
    // R5: acknowledge is held while master sync stays high
    p_ack_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (msyn && ack) |=> ack);
    // R5: acknowledge released once master sync is low
    p_ack_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !msyn |=> !ack);
endmodule

// File: rtl/bsr_lane_store.sv
// Byte-lane storage: one register slice per lane, each loaded only when its
// own lane enable is high. Assumes DATA_W is a multiple of LANE_W.
module bsr_lane_store #(
    parameter int DATA_W = 16,
    parameter int LANE_W = 8,
    localparam int LANES = DATA_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANES-1:0]  lane_we,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // Lane slice: cleared on reset, loaded when its enable is high.
        always_ff @(posedge clk) begin
            if (!rst_n)          q[i*LANE_W +: LANE_W] <= '0;
            else if (lane_we[i]) q[i*LANE_W +: LANE_W] <= d[i*LANE_W +: LANE_W];
        end
    end
endmodule

// File: rtl/bus_slave_reg.sv
// Bus-mapped slave read/write register. Decodes the address and the transfer
// code, produces byte-lane write strobes, gates the read data and runs the
// slave handshake. Assumes all bus inputs are synchronous to clk.
module bus_slave_reg
    import bus_slave_reg_pkg::*;
#(
    parameter int                ADDR_W    = 18,
    parameter int                DATA_W    = 16,
    parameter int                LANE_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 18'h3FF78
) (
    input  logic              clk,
    input  logic              bus_init_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_ctl,
    input  logic              msyn,
    input  logic [DATA_W-1:0] wdata,
    output logic              ssyn,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe,
    output logic [DATA_W-1:0] reg_q
);
    localparam int LANES      = DATA_W / LANE_W;
    localparam int LANE_SEL_W = $clog2(LANES);

    xfer_e            xfer;
    logic             hit;
    logic             is_read;
    logic             is_write;
    logic             wr_strobe;
    logic [LANES-1:0] lane_we;

    bsr_addr_match #(
        .ADDR_W     (ADDR_W),
        .LANE_SEL_W (LANE_SEL_W),
        .BASE_ADDR  (BASE_ADDR)
    ) u_match (
        .addr (bus_addr),
        .hit  (hit)
    );

    bsr_handshake u_hs (
        .clk   (clk),
        .rst_n (bus_init_n),
        .msyn  (msyn),
        .hit   (hit),
        .ack   (ssyn)
    );

    // Transfer decode: classify the control code.
    always_comb begin
        xfer     = xfer_e'(bus_ctl);
        is_read  = (xfer == XF_READ) || (xfer == XF_READ_HOLD);
        is_write = (xfer == XF_WRITE_WORD) || (xfer == XF_WRITE_BYTE);
        wr_strobe = msyn & hit & ~ssyn & is_write;
    end

    // Lane enables: all lanes for a word write, the addressed lane for a byte write.
    for (genvar i = 0; i < LANES; i++) begin : g_we
        always_comb begin
            lane_we[i] = wr_strobe &
                ((xfer == XF_WRITE_WORD) ||
                 (bus_addr[LANE_SEL_W-1:0] == LANE_SEL_W'(i)));
        end
    end

    bsr_lane_store #(
        .DATA_W (DATA_W),
        .LANE_W (LANE_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (bus_init_n),
        .lane_we (lane_we),
        .d       (wdata),
        .q       (reg_q)
    );

    // Read gating: drive only during a read to this address outside initialise.
    always_comb begin
        rdata_oe = bus_init_n & msyn & hit & is_read;
        rdata    = rdata_oe ? reg_q : '0;
    end

    // R7: nothing is presented on the read lines unless driving
    p_no_drive_r7: assert property (@(posedge clk) disable iff (!bus_init_n)
        !rdata_oe |-> (rdata == '0));
    // R8: read transfers leave the register untouched
    p_read_keeps_r8: assert property (@(posedge clk) disable iff (!bus_init_n)
        (msyn && !bus_ctl[1]) |=> $stable(reg_q));
    // R6: no second write once the acknowledge is held
    p_single_write_r6: assert property (@(posedge clk) disable iff (!bus_init_n)
        (ssyn && msyn) |=> $stable(reg_q));
    // R3: an address miss never raises the acknowledge
    p_miss_no_ack_r3: assert property (@(posedge clk) disable iff (!bus_init_n)
        (!ssyn && (!msyn || !hit)) |=> !ssyn);
    // R2: low-lane byte write keeps the upper byte
    p_low_lane_keeps_r2: assert property (@(posedge clk) disable iff (!bus_init_n)
        (msyn && hit && !ssyn && bus_ctl == 2'b11 && !bus_addr[0])
        |=> $stable(reg_q[DATA_W-1:LANE_W]));
endmodule

// File: tb/bus_slave_reg_bench.sv
module bus_slave_reg_bench;
    localparam logic [17:0] BASE = 18'h3FF78;

    logic        clk = 1'b0;
    logic        bus_init_n = 1'b0;
    logic [17:0] bus_addr = '0;
    logic [1:0]  bus_ctl = 2'b00;
    logic        msyn = 1'b0;
    logic [15:0] wdata = '0;
    logic        ssyn;
    logic [15:0] rdata;
    logic        rdata_oe;
    logic [15:0] reg_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference model state
    logic [15:0] m_reg = '0;
    logic        m_ack = 1'b0;

    always #5 clk = ~clk;

    bus_slave_reg u_bus_slave_reg (
        .clk(clk), .bus_init_n(bus_init_n), .bus_addr(bus_addr),
        .bus_ctl(bus_ctl), .msyn(msyn), .wdata(wdata), .ssyn(ssyn),
        .rdata(rdata), .rdata_oe(rdata_oe), .reg_q(reg_q)
    );

    function automatic bit m_hit();
        return bus_addr[17:1] == BASE[17:1];
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
        end
    endtask

    // Reference model update at each rising edge
    always @(posedge clk) begin
        if (!bus_init_n) begin
            m_reg <= '0;
            m_ack <= 1'b0;
        end else begin
            if (msyn && m_hit() && !m_ack && bus_ctl[1]) begin
                if (bus_ctl == 2'b10)      m_reg <= wdata;
                else if (bus_addr[0])      m_reg[15:8] <= wdata[15:8];
                else                       m_reg[7:0]  <= wdata[7:0];
            end
            m_ack <= msyn && (m_ack || m_hit());
        end
    end

    // Compare on every falling edge, before the stimulus changes
    always @(negedge clk) begin
        logic exp_oe;
        exp_oe = bus_init_n && msyn && m_hit() && !bus_ctl[1];
        chk("R5 ssyn", {15'd0, ssyn}, {15'd0, m_ack});
        chk("R7 rdata_oe", {15'd0, rdata_oe}, {15'd0, exp_oe});
        chk("R7 rdata", rdata, exp_oe ? m_reg : 16'h0);
        chk("R1/R2 reg_q", reg_q, m_reg);
    end

    // One bus transfer; the data lines change while the acknowledge is held (R6)
    task automatic xfer(logic [17:0] a, logic [1:0] c, logic [15:0] d);
        @(negedge clk); #2;
        bus_addr = a; bus_ctl = c; wdata = d; msyn = 1'b1;
        repeat (3) @(negedge clk);
        #2 wdata = ~d;
        repeat (2) @(negedge clk);
        #2 msyn = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 reset reg_q", reg_q, 16'h0);
        chk("R9 reset ssyn", {15'd0, ssyn}, 16'h0);
        #2 bus_init_n = 1'b1;

        xfer(BASE, 2'b10, 16'hA5C3);
        chk("R1 word write", reg_q, 16'hA5C3);
        chk("R6 single write", reg_q, 16'hA5C3);
        xfer(BASE, 2'b11, 16'h1177);
        chk("R2 low byte", reg_q, 16'hA577);
        xfer(BASE | 18'h1, 2'b11, 16'h3C00);
        chk("R2 high byte", reg_q, 16'h3C77);
        xfer(BASE ^ 18'h4, 2'b10, 16'hFFFF);
        chk("R3 miss ignored", reg_q, 16'h3C77);
        xfer(BASE | 18'h1, 2'b10, 16'h0F0F);
        chk("R4 odd word write", reg_q, 16'h0F0F);

        // Read and read-with-pause: sample the driven data mid-transfer
        for (int k = 0; k < 2; k++) begin
            @(negedge clk); #2;
            bus_addr = BASE | 18'(k); bus_ctl = 2'(k); msyn = 1'b1;
            @(negedge clk); #1;
            chk("R7 read data", rdata, 16'h0F0F);
            chk("R4 read odd/even oe", {15'd0, rdata_oe}, 16'h1);
            #1;
            repeat (2) @(negedge clk);
            #2 msyn = 1'b0;
            repeat (2) @(negedge clk);
            chk("R8 read keeps", reg_q, 16'h0F0F);
        end

        // Initialise in the middle of a held read
        @(negedge clk); #2;
        bus_addr = BASE; bus_ctl = 2'b00; msyn = 1'b1;
        repeat (2) @(negedge clk);
        #2 bus_init_n = 1'b0;
        @(negedge clk); #1;
        chk("R9 init clears reg", reg_q, 16'h0);
        chk("R9 init oe low", {15'd0, rdata_oe}, 16'h0);
        #1 msyn = 1'b0; bus_init_n = 1'b1;
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule